// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose register space is organised as a ring of overlapping windows. A 5-bit architectural register number is translated through the current window pointer into a physical storage slot. Eight globals are visible from every window. Each window owns eight private locals. Its eight outputs are the same storage as the inputs of the next window down the ring. Two combinational read ports and one write port serve the datapath.

Two commands move the window pointer. A save moves it down by one and a restore moves it up by one, both wrapping modulo the window count. An invalid-window mask holds one bit per window. When a move would land on a window marked invalid, the pointer is left alone and a one-cycle trap pulse is raised: overflow for a save, underflow for a restore. A trap handler outside the block then spills or fills memory and rewrites the pointer and mask through a load port.

Top module: `rwin_regfile`

## Requirements
- R1: Architectural numbers 1..7 address global storage that is the same whatever the window pointer holds.
- R2: Register number 0 reads as zero on both read ports, and a write to it has no effect.
- R3: A save with no trap sets the pointer to (pointer − 1) mod NWIN. A restore with no trap sets it to (pointer + 1) mod NWIN. The new pointer is visible the cycle after the command.
- R4: In window w, numbers 16..23 address locals that belong to w alone. Numbers 24..31 address the inputs of w. Numbers 8..15 address the inputs of window (w − 1) mod NWIN.
- R5: A save whose target window has its mask bit at 1 leaves the pointer and registers unchanged, and drives `ovf_trap` high for the following cycle.
- R6: A restore whose target window has its mask bit at 1 leaves the pointer unchanged, and drives `unf_trap` high for the following cycle.
- R7: Each trap output is high for exactly one cycle per trapping command, and the two trap outputs are never high together.
- R8: Reads return the value held before the current clock edge, so a write and a read of the same register in one cycle return the old value. A write in the same cycle as a save or restore uses the pointer from before the move.
- R9: Reset clears the pointer, the mask, both trap outputs and all storage. While `ctl_ld_en` is 1, the pointer and mask are loaded from `ctl_ld_ptr` and `ctl_ld_mask` (mask bit i belongs to window i), and any save or restore in that cycle is ignored.
- R10: A save and a restore asserted in the same cycle cause no pointer movement and no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| win_save | input | 1 | Move the window pointer down one |
| win_restore | input | 1 | Move the window pointer up one |
| ctl_ld_en | input | 1 | Load pointer and mask |
| ctl_ld_ptr | input | log2(NWIN) | Pointer value to load |
| ctl_ld_mask | input | NWIN | Mask value to load |
| cur_ptr | output | log2(NWIN) | Current window pointer |
| inv_mask | output | NWIN | Current invalid-window mask |
| ovf_trap | output | 1 | Window overflow pulse |
| unf_trap | output | 1 | Window underflow pulse |

## Verification
The bench builds the block with its defaults: eight windows of 32-bit registers. With these values the wrap from pointer 0 to 7 on a save, and from 7 to 0 on a restore, is reached in a few commands. The sharing of outputs and inputs between neighbouring windows can be followed across the wrap point. With eight mask bits, an invalid window can be placed next to a valid one, so the bench can show a trap in one direction and a clean move in the other from the same pointer.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
package rwin_pkg;

    // Register class from the top two bits of an architectural number.
    typedef enum logic [1:0] {
        CLS_GLOBAL = 2'd0,
        CLS_OUT    = 2'd1,
        CLS_LOCAL  = 2'd2,
        CLS_IN     = 2'd3
    } reg_class_e;

    localparam int unsigned ARCH_W    = 5;
    localparam int unsigned GLOBAL_N  = 8;
    localparam int unsigned PER_WIN_N = 16;

    function automatic reg_class_e classify(input logic [ARCH_W-1:0] arch);
        return reg_class_e'(arch[4:3]);
    endfunction

endpackage

// File: rtl/rwin_map.sv
`timescale 1ns/1ps
// Architectural number + window pointer -> physical slot.
// Physical layout: slots 0..7 globals, then per window w (16 slots):
// w*16+0..7 locals, w*16+8..15 inputs. Outputs of w are inputs of w-1.
module rwin_map #(
    parameter int unsigned PTR_W  = 3,
    parameter int unsigned PHYS_W = 8
) (
    input  logic [4:0]        arch_idx,
    input  logic [PTR_W-1:0]  ptr,
    output logic [PHYS_W-1:0] phys_idx,
    output logic              is_zero
);
    import rwin_pkg::*;

    logic [2:0]       offs;
    logic [PTR_W-1:0] below;
    reg_class_e       cls;

    always_comb begin
        cls      = classify(arch_idx);
        offs     = arch_idx[2:0];
        below    = ptr - PTR_W'(1);
        is_zero  = (arch_idx == 5'd0);
        phys_idx = '0;
        unique case (cls)
            CLS_GLOBAL: phys_idx = PHYS_W'(offs);
            CLS_OUT:    phys_idx = PHYS_W'(GLOBAL_N) + PHYS_W'({below, 1'b1, offs});
            CLS_LOCAL:  phys_idx = PHYS_W'(GLOBAL_N) + PHYS_W'({ptr,   1'b0, offs});
            CLS_IN:     phys_idx = PHYS_W'(GLOBAL_N) + PHYS_W'({ptr,   1'b1, offs});
            default:    phys_idx = '0;
        endcase
    end
endmodule

// File: rtl/rwin_store.sv
`timescale 1ns/1ps
module rwin_store #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned DEPTH  = 136,
    parameter int unsigned PHYS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [PHYS_W-1:0] raddr_a,
    input  logic [PHYS_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b
);
    logic [XLEN-1:0] cell_d [DEPTH];
    logic [XLEN-1:0] cell_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cell_d[i] = cell_q[i];
        end
        if (we && (int'(waddr) < DEPTH)) begin
            cell_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) cell_q[i] <= '0;
            else        cell_q[i] <= cell_d[i];
        end
    end

    // Old-value read: data comes from the registered array.
    always_comb begin
        rdata_a = (int'(raddr_a) < DEPTH) ? cell_q[raddr_a] : '0;
        rdata_b = (int'(raddr_b) < DEPTH) ? cell_q[raddr_b] : '0;
    end
endmodule

// File: rtl/rwin_ptr_ctl.sv
`timescale 1ns/1ps
module rwin_ptr_ctl #(
    parameter int unsigned NWIN  = 8,
    parameter int unsigned PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             ld_en,
    input  logic [PTR_W-1:0] ld_ptr,
    input  logic [NWIN-1:0]  ld_mask,
    output logic [PTR_W-1:0] ptr,
    output logic [NWIN-1:0]  mask,
    output logic             ovf,
    output logic             unf
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [NWIN-1:0]  mask;
        logic             ovf;
        logic             unf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [PTR_W-1:0] dn_ptr, up_ptr;
    logic             do_save, do_restore;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ovf  = 1'b0;
        ctl_d.unf  = 1'b0;
        dn_ptr     = ctl_q.ptr - PTR_W'(1);
        up_ptr     = ctl_q.ptr + PTR_W'(1);
        do_save    = save_req && !restore_req && !ld_en;
        do_restore = restore_req && !save_req && !ld_en;
        if (ld_en) begin
            ctl_d.ptr  = ld_ptr;
            ctl_d.mask = ld_mask;
        end else if (do_save) begin
            if (ctl_q.mask[dn_ptr]) ctl_d.ovf = 1'b1;
            else                    ctl_d.ptr = dn_ptr;
        end else if (do_restore) begin
            if (ctl_q.mask[up_ptr]) ctl_d.unf = 1'b1;
            else                    ctl_d.ptr = up_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ptr  = ctl_q.ptr;
    assign mask = ctl_q.mask;
    assign ovf  = ctl_q.ovf;
    assign unf  = ctl_q.unf;
endmodule

// File: rtl/rwin_regfile.sv
`timescale 1ns/1ps
module rwin_regfile #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned XLEN = 32,
    localparam int unsigned PTR_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       rd_a_idx,
    output logic [XLEN-1:0]  rd_a_data,
    input  logic [4:0]       rd_b_idx,
    output logic [XLEN-1:0]  rd_b_data,
    input  logic             wr_en,
    input  logic [4:0]       wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             win_save,
    input  logic             win_restore,
    input  logic             ctl_ld_en,
    input  logic [PTR_W-1:0] ctl_ld_ptr,
    input  logic [NWIN-1:0]  ctl_ld_mask,
    output logic [PTR_W-1:0] cur_ptr,
    output logic [NWIN-1:0]  inv_mask,
    output logic             ovf_trap,
    output logic             unf_trap
);
    localparam int unsigned DEPTH  = rwin_pkg::GLOBAL_N + rwin_pkg::PER_WIN_N * NWIN;
    localparam int unsigned PHYS_W = $clog2(DEPTH);
    localparam int unsigned NPORT  = 3;   // port 0: read A, 1: read B, 2: write

    logic [4:0]        arch_idx [NPORT];
    logic [PHYS_W-1:0] phys_idx [NPORT];
    logic              zero_hit [NPORT];
    logic [XLEN-1:0]   raw_a, raw_b;

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;

    generate
        for (genvar gp = 0; gp < NPORT; gp++) begin : g_map
            rwin_map #(.PTR_W(PTR_W), .PHYS_W(PHYS_W)) u_map (
                .arch_idx (arch_idx[gp]),
                .ptr      (cur_ptr),
                .phys_idx (phys_idx[gp]),
                .is_zero  (zero_hit[gp])
            );
        end
    endgenerate

    rwin_store #(.XLEN(XLEN), .DEPTH(DEPTH), .PHYS_W(PHYS_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && !zero_hit[2]),
        .waddr   (phys_idx[2]),
        .wdata   (wr_data),
        .raddr_a (phys_idx[0]),
        .raddr_b (phys_idx[1]),
        .rdata_a (raw_a),
        .rdata_b (raw_b)
    );

    assign rd_a_data = zero_hit[0] ? '0 : raw_a;
    assign rd_b_data = zero_hit[1] ? '0 : raw_b;

    rwin_ptr_ctl #(.NWIN(NWIN), .PTR_W(PTR_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (win_save),
        .restore_req (win_restore),
        .ld_en       (ctl_ld_en),
        .ld_ptr      (ctl_ld_ptr),
        .ld_mask     (ctl_ld_mask),
        .ptr         (cur_ptr),
        .mask        (inv_mask),
        .ovf         (ovf_trap),
        .unf         (unf_trap)
    );
endmodule

// File: rtl/rwin_regfile_chk.sv
`timescale 1ns/1ps
module rwin_regfile_chk #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned XLEN = 32,
    localparam int unsigned PTR_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       rd_a_idx,
    input logic [XLEN-1:0]  rd_a_data,
    input logic [4:0]       rd_b_idx,
    input logic [XLEN-1:0]  rd_b_data,
    input logic             win_save,
    input logic             win_restore,
    input logic             ctl_ld_en,
    input logic [PTR_W-1:0] ctl_ld_ptr,
    input logic [NWIN-1:0]  ctl_ld_mask,
    input logic [PTR_W-1:0] cur_ptr,
    input logic [NWIN-1:0]  inv_mask,
    input logic             ovf_trap,
    input logic             unf_trap
);
    logic [PTR_W-1:0] ptr_dn, ptr_up;
    assign ptr_dn = cur_ptr - PTR_W'(1);
    assign ptr_up = cur_ptr + PTR_W'(1);

    assert_zero_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_a_idx == 5'd0) |-> (rd_a_data == '0)) and ((rd_b_idx == 5'd0) |-> (rd_b_data == '0)));

    assert_save_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_save && !win_restore && !ctl_ld_en && !inv_mask[ptr_dn]) |=> (cur_ptr == PTR_W'($past(cur_ptr) - PTR_W'(1))));

    assert_restore_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_restore && !win_save && !ctl_ld_en && !inv_mask[ptr_up]) |=> (cur_ptr == PTR_W'($past(cur_ptr) + PTR_W'(1))));

    assert_no_overflow_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> (cur_ptr == $past(cur_ptr)) && $past(win_save && !win_restore && !ctl_ld_en));

    assert_no_underflow_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> (cur_ptr == $past(cur_ptr)) && $past(win_restore && !win_save && !ctl_ld_en));

    assert_traps_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap, unf_trap}));

    assert_load_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ld_en |=> (cur_ptr == $past(ctl_ld_ptr)) && (inv_mask == $past(ctl_ld_mask)) && !ovf_trap && !unf_trap);

    assert_both_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_save && win_restore && !ctl_ld_en) |=> $stable(cur_ptr) && !ovf_trap && !unf_trap);
endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .win_save    (win_save),
    .win_restore (win_restore),
    .ctl_ld_en   (ctl_ld_en),
    .ctl_ld_ptr  (ctl_ld_ptr),
    .ctl_ld_mask (ctl_ld_mask),
    .cur_ptr     (cur_ptr),
    .inv_mask    (inv_mask),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/rwin_regfile_test.sv
`timescale 1ns/1ps
module rwin_regfile_test;
    localparam int unsigned NWIN  = 8;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned PTR_W = 3;
    localparam int unsigned NVEC  = 13;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [4:0]       rd_a_idx, rd_b_idx, wr_idx;
    logic [XLEN-1:0]  rd_a_data, rd_b_data, wr_data;
    logic             wr_en, win_save, win_restore, ctl_ld_en;
    logic [PTR_W-1:0] ctl_ld_ptr, cur_ptr;
    logic [NWIN-1:0]  ctl_ld_mask, inv_mask;
    logic             ovf_trap, unf_trap;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rwin_regfile #(.NWIN(NWIN), .XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .win_save(win_save), .win_restore(win_restore),
        .ctl_ld_en(ctl_ld_en), .ctl_ld_ptr(ctl_ld_ptr), .ctl_ld_mask(ctl_ld_mask),
        .cur_ptr(cur_ptr), .inv_mask(inv_mask),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        sv;
        logic        rs;
        logic        we;
        logic [4:0]  widx;
        logic [31:0] wdat;
        logic [4:0]  ridx;
        logic [31:0] erd;    // read A value before the edge
        logic [2:0]  eptr;   // pointer after the edge
    } vec_t;

    // Starts at pointer 0, mask 0, storage cleared.
    localparam vec_t TBL [NVEC] = '{
        '{4'd8,  1'b0, 1'b0, 1'b1, 5'd8,  32'h11, 5'd8,  32'h0,  3'd0}, // R8 old value on same-cycle write
        '{4'd8,  1'b0, 1'b0, 1'b1, 5'd16, 32'h22, 5'd8,  32'h11, 3'd0},
        '{4'd3,  1'b1, 1'b0, 1'b0, 5'd0,  32'h0,  5'd16, 32'h22, 3'd7}, // R3 save wraps 0 -> 7
        '{4'd4,  1'b0, 1'b0, 1'b1, 5'd16, 32'h33, 5'd24, 32'h11, 3'd7}, // R4 inputs of 7 = outputs of 0
        '{4'd4,  1'b0, 1'b0, 1'b1, 5'd1,  32'h44, 5'd16, 32'h33, 3'd7},
        '{4'd3,  1'b0, 1'b1, 1'b0, 5'd0,  32'h0,  5'd1,  32'h44, 3'd0}, // R3 restore wraps 7 -> 0
        '{4'd4,  1'b0, 1'b0, 1'b1, 5'd0,  32'hFF, 5'd16, 32'h22, 3'd0}, // R4 locals of 0 kept
        '{4'd2,  1'b0, 1'b0, 1'b0, 5'd0,  32'h0,  5'd0,  32'h0,  3'd0}, // R2 r0 write dropped
        '{4'd1,  1'b0, 1'b1, 1'b0, 5'd0,  32'h0,  5'd1,  32'h44, 3'd1}, // R1 global in window 0
        '{4'd4,  1'b0, 1'b0, 1'b1, 5'd24, 32'h55, 5'd8,  32'h0,  3'd1},
        '{4'd8,  1'b0, 1'b1, 1'b0, 5'd0,  32'h0,  5'd24, 32'h55, 3'd2},
        '{4'd4,  1'b0, 1'b0, 1'b0, 5'd0,  32'h0,  5'd8,  32'h55, 3'd2}, // R4 outputs of 2 = inputs of 1
        '{4'd10, 1'b1, 1'b1, 1'b0, 5'd0,  32'h0,  5'd8,  32'h55, 3'd2}  // R10 both commands: no move
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        win_save = 1'b0; win_restore = 1'b0;
        ctl_ld_en = 1'b0; ctl_ld_ptr = '0; ctl_ld_mask = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rd_a_idx = 5'd5; rd_b_idx = 5'd0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 reset pointer", 32'(cur_ptr), 32'd0);
        check("R9 reset mask", 32'(inv_mask), 32'd0);
        check("R9 reset traps", {30'd0, ovf_trap, unf_trap}, 32'd0);
        check("R9 reset storage", rd_a_data, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            win_save = TBL[i].sv; win_restore = TBL[i].rs;
            wr_en = TBL[i].we; wr_idx = TBL[i].widx; wr_data = TBL[i].wdat;
            rd_a_idx = TBL[i].ridx;
            #1;
            check($sformatf("R%0d vec%0d read", TBL[i].req, i), rd_a_data, TBL[i].erd);
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d pointer", TBL[i].req, i), 32'(cur_ptr), 32'(TBL[i].eptr));
            check($sformatf("R7 vec%0d no trap", i), {30'd0, ovf_trap, unf_trap}, 32'd0);
        end

        // R9: load wins over a save in the same cycle
        @(negedge clk);
        idle_inputs();
        ctl_ld_en = 1'b1; ctl_ld_ptr = 3'd3; ctl_ld_mask = 8'h04; win_save = 1'b1;
        @(posedge clk); #1;
        check("R9 load pointer", 32'(cur_ptr), 32'd3);
        check("R9 load mask", 32'(inv_mask), 32'h04);
        check("R9 load no trap", {30'd0, ovf_trap, unf_trap}, 32'd0);

        // R5: save into window 2 (invalid)
        @(negedge clk);
        idle_inputs(); win_save = 1'b1;
        @(posedge clk); #1;
        check("R5 overflow pulse", 32'(ovf_trap), 32'd1);
        check("R5 pointer held", 32'(cur_ptr), 32'd3);
        @(negedge clk);
        idle_inputs();
        @(posedge clk); #1;
        check("R7 overflow one cycle", {30'd0, ovf_trap, unf_trap}, 32'd0);

        // R3: restore from 3 to valid window 4 while window 2 is invalid
        @(negedge clk);
        win_restore = 1'b1;
        @(posedge clk); #1;
        check("R3 restore to valid", 32'(cur_ptr), 32'd4);
        check("R3 no underflow", 32'(unf_trap), 32'd0);

        // R6: pointer 1, restore into window 2 (invalid)
        @(negedge clk);
        idle_inputs(); ctl_ld_en = 1'b1; ctl_ld_ptr = 3'd1; ctl_ld_mask = 8'h04;
        @(negedge clk);
        idle_inputs(); win_restore = 1'b1;
        @(posedge clk); #1;
        check("R6 underflow pulse", 32'(unf_trap), 32'd1);
        check("R6 pointer held", 32'(cur_ptr), 32'd1);
        check("R7 no overflow with underflow", 32'(ovf_trap), 32'd0);
        @(negedge clk);
        idle_inputs();
        @(posedge clk); #1;
        check("R7 underflow one cycle", 32'(unf_trap), 32'd0);

        // R1 / R2 on port B in window 1
        @(negedge clk);
        rd_b_idx = 5'd1; #1;
        check("R1 global seen from window 1", rd_b_data, 32'h44);
        rd_b_idx = 5'd0; #1;
        check("R2 port B zero", rd_b_data, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule